// File: doc/BRIEF.md
# Round-Robin Worker Pool

This block takes a single stream of 32-bit signed words and works on them in four parallel compute lanes. Each lane returns twice its input plus one. A dispatcher hands incoming words to the lanes in a fixed rotation. A collector reads the results back in the same rotation, so the output stream keeps the order of the input stream even though each lane runs on its own.

Each lane has a small FIFO in front of a one-stage compute register. A lane does work whenever its FIFO holds a word, and there is no start or done control. Both stream edges use a valid/ready handshake: a word moves on a clock edge where valid and ready are both high. The dispatcher never skips a lane. If the lane it points at is full, it stalls. The collector never skips a lane either. If the lane it points at has no result, it waits, even when other lanes hold results.

Top module: `rr_worker_pool`

## Requirements
- R1: After synchronous active-high reset, `out_valid` is 0, `in_ready` is 1, and both rotation pointers point at lane 0.
- R2: Every output word equals 2*x+1 for its input word x, computed in 32-bit two's complement with wraparound (0x7FFFFFFF gives 0xFFFFFFFF, 0x80000000 gives 0x00000001).
- R3: Output words leave in exactly the order their input words were accepted. The dispatcher sends accepted words to lanes 0,1,2,3,0,... and the collector drains the lanes in the same order.
- R4: The dispatcher moves to the next lane only when the current lane accepts a word. With `out_ready` held low, the block accepts exactly 4*(FIFO_DEPTH+1) = 12 words and then holds `in_ready` low.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R6: With `in_valid` and `out_ready` held high, `in_ready` never drops. The first result is valid two clock edges after the first word is accepted, and then one result leaves on every cycle.
- R7: A reset in the middle of a stream discards every held word. The first word sent after the reset comes out first, through lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Lane currently selected by the dispatcher can take a word |
| in_data | input | 32 | Input word, signed |
| out_valid | output | 1 | Result from the lane selected by the collector is present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Result word, signed |

## Verification
A table of twelve words runs through the block under four handshake patterns: free flow, downstream ready on alternate cycles, downstream ready two cycles in three with gaps in the input, and input valid two cycles in three. The table covers zero, small values, all-ones, both signed extremes and alternating bit patterns. This catches wrong arithmetic and wraparound. Only the stalled patterns let the lane fill levels drift apart, so they are what expose a dispatcher or collector that skips a lane, which shows up as reordering. A full-backpressure run measures the exact capacity and the output hold behaviour. A timed free-flow run pins down the two-edge latency and the one-word-per-cycle rate. A reset in the middle of a stream, followed by a single word, shows whether both pointers and all FIFOs really return to lane 0 and empty.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
    localparam int DATA_W     = 32;
    localparam int LANES      = 4;
    localparam int FIFO_DEPTH = 2;
    localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1;

    typedef logic [LANE_W-1:0]        lane_t;
    typedef logic signed [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

    function automatic lane_t next_lane(lane_t cur);
        return (cur == lane_t'(LANES - 1)) ? '0 : cur + lane_t'(1);
    endfunction

    // Lane arithmetic: doubled input plus one, wrapping in DATA_W bits
    function automatic word_t lane_calc(word_t x);
        return (x <<< 1) + word_t'(1);
    endfunction
endpackage

// File: rtl/rrp_fifo.sv
module rrp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [WIDTH-1:0] push_data,
    output logic             pop_valid,
    input  logic             pop_ready,
    output logic [WIDTH-1:0] pop_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign push_ready = (count != CNT_W'(DEPTH));
    assign pop_valid  = (count != '0);
    assign pop_data   = store[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                store[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rrp_worker.sv
module rrp_worker
    import rrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  word_t in_data,
    output logic  out_valid,
    input  logic  out_ready,
    output word_t out_data
);
    beat_t res_q;

    assign in_ready  = !res_q.valid || out_ready;
    assign out_valid = res_q.valid;
    assign out_data  = res_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (in_valid && in_ready) begin
            res_q.valid <= 1'b1;
            res_q.data  <= lane_calc(in_data);
        end else if (out_ready) begin
            res_q.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rrp_dispatch.sv
module rrp_dispatch
    import rrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  logic  lane_ready [LANES],
    output logic  lane_valid [LANES],
    output lane_t sel
);
    assign in_ready = lane_ready[sel];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_valid[g] = in_valid && (sel == lane_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (in_valid && in_ready)
            sel <= next_lane(sel);
    end
endmodule

// File: rtl/rrp_collect.sv
module rrp_collect
    import rrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lane_valid [LANES],
    input  word_t lane_data  [LANES],
    output logic  lane_ready [LANES],
    output logic  out_valid,
    input  logic  out_ready,
    output word_t out_data,
    output lane_t sel
);
    assign out_valid = lane_valid[sel];
    assign out_data  = lane_data[sel];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ready[g] = out_ready && (sel == lane_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (out_valid && out_ready)
            sel <= next_lane(sel);
    end
endmodule

// File: rtl/rr_worker_pool.sv
module rr_worker_pool
    import rrp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);
    lane_t disp_sel, coll_sel;
    logic  push_valid [LANES];
    logic  push_ready [LANES];
    logic  fifo_valid [LANES];
    logic  fifo_ready [LANES];
    word_t fifo_data  [LANES];
    logic  res_valid  [LANES];
    logic  res_ready  [LANES];
    word_t res_data   [LANES];
    word_t merged;

    rrp_dispatch u_disp (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .lane_ready(push_ready), .lane_valid(push_valid),
        .sel(disp_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rrp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst(rst),
            .push_valid(push_valid[g]), .push_ready(push_ready[g]),
            .push_data(in_data),
            .pop_valid(fifo_valid[g]), .pop_ready(fifo_ready[g]),
            .pop_data(fifo_data[g])
        );
        rrp_worker u_work (
            .clk(clk), .rst(rst),
            .in_valid(fifo_valid[g]), .in_ready(fifo_ready[g]),
            .in_data(fifo_data[g]),
            .out_valid(res_valid[g]), .out_ready(res_ready[g]),
            .out_data(res_data[g])
        );
    end

    rrp_collect u_coll (
        .clk(clk), .rst(rst),
        .lane_valid(res_valid), .lane_data(res_data), .lane_ready(res_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(merged),
        .sel(coll_sel)
    );

    assign out_data = merged;
endmodule

// File: rtl/rrp_checker.sv
module rrp_checker
    import rrp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input lane_t       disp_sel,
    input lane_t       coll_sel
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!out_valid && in_ready && disp_sel == '0 && coll_sel == '0));

    p_disp_step_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> disp_sel == next_lane($past(disp_sel)));

    p_coll_step_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> coll_sel == next_lane($past(coll_sel)));

    p_coll_wait_r3: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(coll_sel));

    p_disp_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> $stable(disp_sel));

    p_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind rr_worker_pool rrp_checker u_chk (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .disp_sel(disp_sel), .coll_sel(coll_sel)
);

// File: tb/tb_rr_worker_pool.sv
module tb_rr_worker_pool;
    localparam int NV = 12;
    localparam logic [31:0] VEC_IN [NV] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0005, 32'hFFFF_FFFF,
        32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFE, 32'h1234_5678,
        32'h4000_0000, 32'hC000_0000, 32'h0000_FFFF, 32'hAAAA_AAAA};
    localparam logic [31:0] VEC_EXP [NV] = '{
        32'h0000_0001, 32'h0000_0003, 32'h0000_000B, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFD, 32'h2468_ACF1,
        32'h8000_0001, 32'h8000_0001, 32'h0001_FFFF, 32'h5555_5555};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rr_worker_pool dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid  = 1'b0;
        out_ready = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // gmode: every gmode-th producer cycle is idle; rmode: every rmode-th consumer cycle not ready
    task automatic run_stream(input int rmode, input int gmode, input string tag);
        int sent = 0;
        int got  = 0;
        fork
            begin
                int cp = 0;
                while (sent < NV) begin
                    logic v, hs;
                    @(negedge clk);
                    cp++;
                    v = !(gmode != 0 && (cp % gmode) == 0);
                    in_valid = v;
                    in_data  = VEC_IN[sent];
                    #1;
                    hs = v && in_ready;
                    @(posedge clk);
                    if (hs) sent++;
                end
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin
                int cc = 0;
                while (got < NV && cc < 2000) begin
                    logic r;
                    @(negedge clk);
                    cc++;
                    r = !(rmode != 0 && (cc % rmode) == 0);
                    out_ready = r;
                    #1;
                    if (out_valid && r) begin
                        chk({tag, " R2 R3 value/order"}, out_data, VEC_EXP[got]);
                        got++;
                    end
                    @(posedge clk);
                end
                if (got != NV) chk({tag, " R3 output count"}, 32'(got), 32'(NV));
                @(negedge clk);
                out_ready = 1'b0;
            end
        join
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

        // Table walk under several handshake patterns
        run_stream(0, 0, "free");
        run_stream(2, 0, "ready-alt");
        run_stream(3, 3, "ready-gap");
        run_stream(0, 3, "input-gap");

        // R6: latency and rate with both sides open
        do_reset();
        begin
            int acc_lo = 0;
            int first  = -1;
            int last   = -1;
            int outs   = 0;
            out_ready = 1'b1;
            for (int c = 0; c < NV + 6; c++) begin
                @(negedge clk);
                in_valid = (c < NV);
                in_data  = 32'(c * 7 - 20);
                #1;
                if (c < NV && !in_ready) acc_lo++;
                if (out_valid) begin
                    chk("R6 R2 streamed value", out_data, 32'((outs * 7 - 20) * 2 + 1));
                    if (first < 0) first = c;
                    last = c;
                    outs++;
                end
                @(posedge clk);
            end
            in_valid = 1'b0;
            chk("R6 in_ready never low", 32'(acc_lo), 32'd0);
            chk("R6 first result cycle", 32'(first), 32'd2);
            chk("R6 one result per cycle", 32'(last - first), 32'(NV - 1));
        end

        // R4/R5: capacity under full backpressure, then ordered drain
        do_reset();
        begin
            int acc = 0;
            logic [31:0] held;
            out_ready = 1'b0;
            for (int c = 0; c < 24; c++) begin
                logic hs;
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = 32'(1000 + acc * 3);
                #1;
                hs = in_ready;
                @(posedge clk);
                if (hs) acc++;
            end
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            chk("R4 words accepted under stall", 32'(acc), 32'd12);
            chk("R4 in_ready low when full", 32'(in_ready), 32'd0);
            chk("R5 out_valid while stalled", 32'(out_valid), 32'd1);
            held = out_data;
            repeat (3) @(negedge clk);
            #1;
            chk("R5 out_data held", out_data, held);
            chk("R5 out_valid held", 32'(out_valid), 32'd1);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                out_ready = 1'b1;
                #1;
                chk("R4 R3 drain order", out_data, 32'((1000 + k * 3) * 2 + 1));
                @(posedge clk);
            end
            @(negedge clk);
            out_ready = 1'b0;
            #1;
            chk("R4 empty after drain", 32'(out_valid), 32'd0);
        end

        // R7: reset in the middle of a stream
        begin
            int wait_c = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = 32'(50 + k);
                @(posedge clk);
            end
            do_reset();
            #1;
            chk("R7 out_valid after mid reset", 32'(out_valid), 32'd0);
            chk("R7 in_ready after mid reset", 32'(in_ready), 32'd1);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'd100;
            @(posedge clk);
            @(negedge clk);
            in_valid  = 1'b0;
            out_ready = 1'b1;
            #1;
            while (!out_valid && wait_c < 10) begin
                @(negedge clk);
                #1;
                wait_c++;
            end
            chk("R7 first word after reset", out_data, 32'd201);
            chk("R7 output present", 32'(out_valid), 32'd1);
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("R7 no stale word", 32'(out_valid), 32'd0);
            out_ready = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule